// File: doc/BRIEF.md
# Galloping Pattern Memory Tester

This block is a self-test engine for a small synchronous RAM. It drives the RAM's address, write data, write enable and read enable, runs the galloping-pattern sequence over every cell, and checks each read value against the value the sequence expects. The run time grows with the square of the depth, so the engine is meant for characterization-size arrays of a few dozen words, either bit-wide or word-wide.

A run starts with a one-cycle pulse on `start_i` while the engine is idle. The engine first fills the array with the background value. Then, for each base cell in ascending order, it writes the inverted background into the base cell. It then visits every other address in ascending order, reading the base cell and then the visited cell each time. Last, it writes the background back into the base cell. The whole pass runs with a background of all zeros and then again with all ones. The end of the run is marked by a one-cycle `done_o` pulse. `fail_o` stays high from the first mismatch until the next accepted start. With it, the engine records the address and the kind of operation of that first failing read. `stop_on_fail_i` selects between aborting at the first mismatch and running the sequence to its end.

Top module: `galpat_tester`

## Requirements
- R1: After reset, `done_o`, `fail_o`, `mem_we_o` and `mem_re_o` are low and `fail_addr_o` is zero.
- R2: The first cycle after an accepted start begins the fill phase: one write per cycle of all-zero data to addresses 0 to DEPTH-1 in ascending order.
- R3: For each base address b from 0 to DEPTH-1: one write of the inverted background to b; then, for each other address o ascending with o != b, a read of b followed by a read of o; then one write of the background to b.
- R4: After the zero-background pass, the fill phase and the base-cell pass are repeated with an all-ones background.
- R5: With no abort, `done_o` is high for exactly one cycle, 2*DEPTH + 4*DEPTH*DEPTH cycles after the start cycle (cycle 0 is the first fill write).
- R6: The RAM returns read data one cycle after the request. A read of the base cell is expected to return the inverted background, and a read of any other cell is expected to return the background.
- R7: The first mismatch sets `fail_o` and captures the read address in `fail_addr_o` and the operation in `fail_op_o`. In that code, bit 1 is the background (0 zeros, 1 ones) and bit 0 is the read kind (0 base read, 1 other read). Later mismatches change none of these.
- R8: With `stop_on_fail_i` low the run continues to its normal end after a mismatch. With it high, `done_o` rises in the cycle after the one in which the mismatching data is compared.
- R9: A `start_i` pulse while a run is in progress has no effect: the run is neither restarted nor lengthened.
- R10: An accepted start clears `fail_o`, so a clean run after a failing one ends with `fail_o` low.
- R11: Write enable and read enable are never high in the same cycle, and the RAM address stays below DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins a run when the engine is idle |
| stop_on_fail_i | input | 1 | Abort the run at the first mismatch |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_o | output | 1 | A mismatch has been seen in this run |
| fail_addr_o | output | AW | Address of the first failing read |
| fail_op_o | output | 2 | {background, read kind} of the first failing read |
| mem_addr_o | output | AW | RAM address |
| mem_we_o | output | 1 | RAM write enable |
| mem_re_o | output | 1 | RAM read enable |
| mem_wdata_o | output | DATA_W | RAM write data |
| mem_rdata_i | input | DATA_W | RAM read data, one cycle after the read request |

## Verification
The hardest case to reach is a failure that shows only in the all-ones pass. Any plain stuck bit already trips a read in the zero pass. To get past this, the bench's RAM model arms its fault only after a chosen cycle, part way through the second pass. This proves that the background bit of the captured code and the late capture path both work. A second case is the capture of the first of many mismatches. A stuck-at-one cell fails first as an other-cell read in the zero pass and again later as a base-cell read in the ones pass, so an engine that overwrote its record would report the wrong operation code.

// File: rtl/galpat_pkg.sv
package galpat_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FILL, ST_SETB, ST_RDB, ST_RDO, ST_RSTB, ST_DONE
  } gp_state_e;

  localparam logic KIND_BASE  = 1'b0;
  localparam logic KIND_OTHER = 1'b1;
endpackage

// File: rtl/galpat_seq.sv
module galpat_seq
  import galpat_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 4,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  output logic              busy_o,
  output logic              clr_o,
  output logic              done_o,
  output logic [AW-1:0]     addr_o,
  output logic              we_o,
  output logic              re_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] exp_o,
  output logic [1:0]        op_o
);
  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
  localparam logic [AW-1:0] LAST2 = AW'(DEPTH - 2);

  gp_state_e         state_q, state_d;
  logic              bg_q, bg_d;
  logic [AW-1:0]     base_q, base_d, idx_q, idx_d;
  logic [DATA_W-1:0] fill;
  logic [AW-1:0]     idx_inc, idx_next;
  logic              last_other;

  assign fill       = {DATA_W{bg_q}};
  assign idx_inc    = idx_q + AW'(1);
  assign idx_next   = (idx_inc == base_q) ? idx_q + AW'(2) : idx_inc;
  assign last_other = (idx_q == LAST) || (idx_q == LAST2 && base_q == LAST);

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_DONE);
  assign clr_o  = (state_q == ST_IDLE) && start_i;

  always_comb begin
    addr_o  = '0;
    we_o    = 1'b0;
    re_o    = 1'b0;
    wdata_o = '0;
    exp_o   = '0;
    op_o    = {bg_q, KIND_BASE};
    unique case (state_q)
      ST_FILL: begin we_o = 1'b1; addr_o = idx_q;  wdata_o = fill;  end
      ST_SETB: begin we_o = 1'b1; addr_o = base_q; wdata_o = ~fill; end
      ST_RDB:  begin re_o = 1'b1; addr_o = base_q; exp_o = ~fill;   end
      ST_RDO: begin
        re_o   = 1'b1;
        addr_o = idx_q;
        exp_o  = fill;
        op_o   = {bg_q, KIND_OTHER};
      end
      ST_RSTB: begin we_o = 1'b1; addr_o = base_q; wdata_o = fill; end
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    bg_d    = bg_q;
    base_d  = base_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_FILL; bg_d = 1'b0; idx_d = '0; base_d = '0;
      end
      ST_FILL: if (idx_q == LAST) begin
        state_d = ST_SETB; base_d = '0;
      end else idx_d = idx_inc;
      ST_SETB: begin
        state_d = ST_RDB;
        idx_d   = AW'(base_q == '0);
      end
      ST_RDB: state_d = ST_RDO;
      ST_RDO: if (last_other) state_d = ST_RSTB;
              else begin state_d = ST_RDB; idx_d = idx_next; end
      ST_RSTB: if (base_q != LAST) begin
        state_d = ST_SETB; base_d = base_q + AW'(1);
      end else if (bg_q) state_d = ST_DONE;
      else begin
        state_d = ST_FILL; bg_d = 1'b1; idx_d = '0;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (abort_i && state_q != ST_IDLE && state_q != ST_DONE) state_d = ST_DONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bg_q    <= 1'b0;
      base_q  <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      bg_q    <= bg_d;
      base_q  <= base_d;
      idx_q   <= idx_d;
    end
  end
endmodule

// File: rtl/galpat_cmp.sv
module galpat_cmp #(
  parameter int DATA_W = 4,
  parameter int AW     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              re_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              mismatch_o,
  output logic              fail_o,
  output logic [AW-1:0]     fail_addr_o,
  output logic [1:0]        fail_op_o
);
  logic              pend_q;
  logic [DATA_W-1:0] exp_q;
  logic [AW-1:0]     addr_q;
  logic [1:0]        op_q;

  assign mismatch_o = pend_q && (rdata_i != exp_q);

  // read request stage, aligned with the RAM's one-cycle latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      exp_q  <= '0;
      addr_q <= '0;
      op_q   <= '0;
    end else begin
      pend_q <= re_i;
      exp_q  <= exp_i;
      addr_q <= addr_i;
      op_q   <= op_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_o      <= 1'b0;
      fail_addr_o <= '0;
      fail_op_o   <= '0;
    end else if (clr_i) begin
      fail_o      <= 1'b0;
      fail_addr_o <= '0;
      fail_op_o   <= '0;
    end else if (mismatch_o && !fail_o) begin
      fail_o      <= 1'b1;
      fail_addr_o <= addr_q;
      fail_op_o   <= op_q;
    end
  end
endmodule

// File: rtl/galpat_tester.sv
module galpat_tester #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 4,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_on_fail_i,
  output logic              done_o,
  output logic              fail_o,
  output logic [AW-1:0]     fail_addr_o,
  output logic [1:0]        fail_op_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic              busy, clr, mismatch;
  logic [DATA_W-1:0] exp;
  logic [1:0]        op;

  galpat_seq #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .abort_i (mismatch && stop_on_fail_i),
    .busy_o  (busy),
    .clr_o   (clr),
    .done_o  (done_o),
    .addr_o  (mem_addr_o),
    .we_o    (mem_we_o),
    .re_o    (mem_re_o),
    .wdata_o (mem_wdata_o),
    .exp_o   (exp),
    .op_o    (op)
  );

  galpat_cmp #(.DATA_W(DATA_W), .AW(AW)) u_cmp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .re_i        (mem_re_o),
    .addr_i      (mem_addr_o),
    .exp_i       (exp),
    .op_i        (op),
    .rdata_i     (mem_rdata_i),
    .mismatch_o  (mismatch),
    .fail_o      (fail_o),
    .fail_addr_o (fail_addr_o),
    .fail_op_o   (fail_op_o)
  );
endmodule

// File: rtl/galpat_tester_sva.sv
module galpat_tester_sva #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          stop_on_fail_i,
  input logic          done_o,
  input logic          fail_o,
  input logic [AW-1:0] fail_addr_o,
  input logic [1:0]    fail_op_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_we_o,
  input logic          mem_re_o,
  input logic          busy
);
  // R11
  no_we_re_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));

  // R11
  addr_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || mem_re_o) |-> (int'(mem_addr_o) < DEPTH));

  // R5
  done_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R5
  done_quiet_ram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_we_o && !mem_re_o);

  // R7
  first_fail_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && busy) |=> fail_o && $stable(fail_addr_o) && $stable(fail_op_o));

  // R8
  stop_ends_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(fail_o) && $past(stop_on_fail_i)) |-> done_o);

  // R9
  run_not_cut_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !done_o) |=> busy);
endmodule

bind galpat_tester galpat_tester_sva #(.DEPTH(DEPTH), .AW(AW)) u_sva (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .stop_on_fail_i (stop_on_fail_i),
  .done_o         (done_o),
  .fail_o         (fail_o),
  .fail_addr_o    (fail_addr_o),
  .fail_op_o      (fail_op_o),
  .mem_addr_o     (mem_addr_o),
  .mem_we_o       (mem_we_o),
  .mem_re_o       (mem_re_o),
  .busy           (busy)
);

// File: tb/galpat_tester_test.sv
`timescale 1ns/1ps
module galpat_tester_test;
  localparam int N    = 16;
  localparam int DW   = 4;
  localparam int AW   = $clog2(N);
  localparam int FULL = 2*N + 4*N*N;
  localparam int NEVER = 1 << 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0;
  logic done, fail, we, re;
  logic [AW-1:0] fail_addr, addr;
  logic [1:0] fail_op;
  logic [DW-1:0] wdata, rdata;

  int checks = 0, errors = 0, cycles = 0;

  always #5 clk = ~clk;

  galpat_tester #(.DEPTH(N), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_on_fail_i(stop),
    .done_o(done), .fail_o(fail), .fail_addr_o(fail_addr), .fail_op_o(fail_op),
    .mem_addr_o(addr), .mem_we_o(we), .mem_re_o(re), .mem_wdata_o(wdata),
    .mem_rdata_i(rdata)
  );

  // behavioural RAM, registered read, optional stuck bits on one address
  logic [DW-1:0] mem [N];
  logic          fault_on = 1'b0;
  int            f_addr = 0;
  logic [DW-1:0] f_sa0 = '0, f_sa1 = '0;

  always @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) begin
      if (fault_on && int'(addr) == f_addr) rdata <= (mem[addr] & ~f_sa0) | f_sa1;
      else rdata <= mem[addr];
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  int done_cyc, fail_at0, fail_end, addr_end, op_end, done_after;

  task automatic run(input bit stop_mode, input int fault_at, input int restart_at);
    @(negedge clk); start = 1'b1; stop = stop_mode;
    @(negedge clk); start = 1'b0;
    done_cyc = -1;
    fail_at0 = fail;
    for (int c = 0; c < 3*FULL; c++) begin
      fault_on = (c >= fault_at);
      start = (c == restart_at);
      if (done) begin
        done_cyc = c; fail_end = fail; addr_end = fail_addr; op_end = fail_op;
        break;
      end
      @(negedge clk);
    end
    start = 1'b0;
    @(negedge clk);
    done_after = done;
    fault_on = 1'b0;
  endtask

  int seq_err[5];
  task automatic expect_op(input int idx, input logic e_we, input logic e_re,
                           input int e_addr, input logic [DW-1:0] e_d);
    if (we !== e_we || re !== e_re || int'(addr) != e_addr || (e_we && wdata !== e_d)) begin
      if (seq_err[idx] == 0)
        $display("sequence deviation: we=%0b re=%0b addr=%0d wd=%0h, want %0b %0b %0d %0h",
                 we, re, addr, wdata, e_we, e_re, e_addr, e_d);
      seq_err[idx]++;
    end
    @(negedge clk);
  endtask

  task automatic test_reset;
    check("R1 done", int'(done), 0);
    check("R1 fail", int'(fail), 0);
    check("R1 we|re", int'(we | re), 0);
    check("R1 fail_addr", int'(fail_addr), 0);
  endtask

  task automatic test_sequence;
    logic [DW-1:0] f;
    foreach (seq_err[i]) seq_err[i] = 0;
    @(negedge clk); start = 1'b1; stop = 1'b0;
    @(negedge clk); start = 1'b0;
    for (int bg = 0; bg < 2; bg++) begin
      f = bg ? '1 : '0;
      for (int a = 0; a < N; a++) expect_op(bg ? 4 : 2, 1'b1, 1'b0, a, f);
      for (int b = 0; b < N; b++) begin
        expect_op(bg ? 4 : 3, 1'b1, 1'b0, b, ~f);
        for (int o = 0; o < N; o++) if (o != b) begin
          expect_op(bg ? 4 : 3, 1'b0, 1'b1, b, '0);
          expect_op(bg ? 4 : 3, 1'b0, 1'b1, o, '0);
        end
        expect_op(bg ? 4 : 3, 1'b1, 1'b0, b, f);
      end
    end
    check("R2 zero fill order", seq_err[2], 0);
    check("R3 base loop order", seq_err[3], 0);
    check("R4 ones pass order", seq_err[4], 0);
    check("R5 done at full length", int'(done), 1);
    check("R6 clean RAM no fail", int'(fail), 0);
    @(negedge clk);
    check("R5 done one cycle", int'(done), 0);
  endtask

  // stuck-at-1 at addr 5: first seen on other-cell read in zero pass, again later
  task automatic test_continue;
    f_addr = 5; f_sa0 = '0; f_sa1 = 4'b0001;
    run(1'b0, 0, NEVER);
    check("R8 continue to full length", done_cyc, FULL);
    check("R7 fail set", fail_end, 1);
    check("R7 first fail addr", addr_end, 5);
    check("R7 first op kept (zero bg, other read)", op_end, 1);
  endtask

  // same fault, abort: read at cycle 26, compare 27, done 28
  task automatic test_stop;
    f_addr = 5; f_sa0 = '0; f_sa1 = 4'b0001;
    run(1'b1, 0, NEVER);
    check("R8 stop done cycle", done_cyc, 28);
    check("R8 stop fail", fail_end, 1);
    check("R7 stop fail addr", addr_end, 5);
    check("R5 no done after abort", done_after, 0);
  endtask

  // stuck-at-0 at addr 3: first seen on base read of base 3
  task automatic test_base_fail;
    f_addr = 3; f_sa0 = 4'b0010; f_sa1 = '0;
    run(1'b0, 0, NEVER);
    check("R6 base expects inverted bg: addr", addr_end, 3);
    check("R6 base read op code", op_end, 0);
  endtask

  // fault armed in the ones pass: other read of 7 at cycle 622
  task automatic test_ones_pass_fail;
    f_addr = 7; f_sa0 = 4'b0001; f_sa1 = '0;
    run(1'b0, 600, NEVER);
    check("R4 ones pass fail seen", fail_end, 1);
    check("R7 ones pass fail addr", addr_end, 7);
    check("R7 ones pass op code", op_end, 3);
    check("R6 ones pass full length", done_cyc, FULL);
  endtask

  task automatic test_restart_ignored;
    f_sa0 = '0; f_sa1 = '0;
    run(1'b0, NEVER, 100);
    check("R10 fail cleared on start", fail_at0, 0);
    check("R9 start while busy ignored", done_cyc, FULL);
    check("R10 clean run no fail", fail_end, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_sequence();
    test_continue();
    test_stop();
    test_restart_ignored();
    test_base_fail();
    test_ones_pass_fail();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule